// File: doc/BRIEF.md
# Flying Capacitor Precharge Sequencer

This block brings the flying capacitors of a multilevel flying capacitor phase leg up to their working voltages before normal modulation starts. When enabled, it closes every switch that puts the flying capacitors in parallel with the DC link. An external supply then ramps the DC link, and the capacitors charge along with it. The block watches strobed voltage samples and opens the switches of one capacitor at a time. The capacitor with the smallest target voltage is released first. Each one is released when its own voltage has qualified against its own target. When the last capacitor of every phase has been released, the block raises `done`, and the modulator takes over. All phases run in parallel from the same enable.

Each capacitor's target is derived from the requested DC-link voltage and the number of levels. A capacitor only qualifies after a programmable number of consecutive valid samples at or above its target, less a programmable margin. A programmable charge window guards against a supply that never gets there. The controller is a five-state machine:
- IDLE goes to CONNECT when `en` is high.
- CONNECT goes to CHARGE on the next edge.
- CHARGE goes to DONE when every phase is finished. Otherwise it goes to FAULT when the window expires.
- DONE and FAULT are held while `en` stays high.
- Any state goes to IDLE one edge after `en` is low.

Top module: `fcpc_precharge`

## Requirements
- R1: While in IDLE (including after reset, with `en` low), every bit of `sw_cmd` is 0 and `done` and `fault` are 0.
- R2: One clock edge after `en` is seen high in IDLE, the block is in CONNECT and every bit of `sw_cmd` is 1. Bit `p*CAPS+k` belongs to capacitor k of phase p, and CAPS = LEVELS-2.
- R3: The threshold of capacitor k is the floor of `vdc_target*(LEVELS-2-k)/(LEVELS-1)` minus `margin`, and a sample qualifies when it is at or above that value. With LEVELS=5, `vdc_target`=1200 and `margin`=10, the thresholds are 890, 590 and 290 for k = 0, 1 and 2.
- R4: In each phase, only the pending capacitor with the lowest target (highest k still connected) is compared. Releases happen in the order k = CAPS-1 down to 0, and the voltages of all other capacitors are ignored.
- R5: A capacitor is released, meaning its `sw_cmd` bit clears, at the edge that takes its `qual_len`-th consecutive qualifying valid sample. A valid sample below the threshold restarts the count, and `qual_len`=0 acts as 1.
- R6: Samples taken while `v_valid` is low neither count toward qualification nor reset the count.
- R7: One edge after the last capacitor of the last phase is released, the block enters DONE. In DONE, `done` is 1, `fault` is 0 and `sw_cmd` is all 0.
- R8: The charge window counts the edges spent in CHARGE. If the count equals `timeout_lim` before completion, FAULT follows on the next edge. In FAULT, `fault` is 1 and `sw_cmd` is all 0, and this holds while `en` stays high.
- R9: If completion and window expiry fall in the same cycle, completion wins and the block enters DONE.
- R10: One edge after `en` is seen low in any state, the block is in IDLE with `sw_cmd`, `done` and `fault` all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request; low returns to IDLE |
| v_valid | input | 1 | Strobe marking `v_cap` as a fresh sample |
| v_cap | input | PHASES*(LEVELS-2)*VW | Capacitor voltage samples, slot `p*CAPS+k` for phase p, capacitor k |
| vdc_target | input | VW | Final DC-link voltage that the targets are derived from |
| margin | input | VW | Amount subtracted from each target before comparison |
| qual_len | input | QW | Consecutive qualifying samples required |
| timeout_lim | input | TW | Charge window length in clock cycles |
| sw_cmd | output | PHASES*(LEVELS-2) | Switch-pair close command per capacitor |
| done | output | 1 | Precharge complete; modulator may start |
| fault | output | 1 | Charge window expired; all switches open |

## Verification
Two events can land in the same cycle: the release of the final capacitor and the expiry of the charge window. To provoke this, all voltages are driven above every target, the strobe is held high and `qual_len` is set to 1. This releases one capacitor per edge. `timeout_lim` is then set to 3, so the window count reaches its limit in exactly the cycle that completion is seen, and DONE must win. The same stimulus with a limit of 2 must end in FAULT, which shows that the tie-break is what decides the outcome.

// File: rtl/fcpc_pkg.sv
package fcpc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CONNECT = 3'd1,
        ST_CHARGE  = 3'd2,
        ST_DONE    = 3'd3,
        ST_FAULT   = 3'd4
    } pc_state_e;
endpackage

// File: rtl/fcpc_thresh.sv
// Per-capacitor comparison thresholds, shared by all phases.
module fcpc_thresh #(
    parameter int LEVELS = 5,
    parameter int VW     = 12
) (
    input  logic [VW-1:0]              vdc_target,
    input  logic [VW-1:0]              margin,
    output logic [(LEVELS-2)*VW-1:0]   thr
);
    localparam int CAPS = LEVELS - 2;
    localparam int MW   = VW + $clog2(LEVELS);

    generate
        for (genvar k = 0; k < CAPS; k++) begin : g_cap
            localparam int NUM = LEVELS - 2 - k;
            logic [MW-1:0] prod;
            logic [VW-1:0] setp;
            logic [VW-1:0] t;
            always_comb begin
                prod = MW'(vdc_target) * MW'(NUM);
                // target never exceeds vdc_target, so it fits in VW bits
                setp = VW'(prod / MW'(LEVELS - 1));
                // margin larger than the target floors the threshold at zero
                if (setp > margin) t = setp - margin;
                else               t = '0;
            end
            assign thr[k*VW +: VW] = t;
        end
    endgenerate
endmodule

// File: rtl/fcpc_leg.sv
// Release tracker for one phase leg: compares the pending capacitor,
// qualifies over consecutive valid samples, and clears its switch bit.
module fcpc_leg #(
    parameter int CAPS = 3,
    parameter int VW   = 12,
    parameter int QW   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               run,
    input  logic               v_valid,
    input  logic [CAPS*VW-1:0] v_leg,
    input  logic [CAPS*VW-1:0] thr,
    input  logic [QW-1:0]      qual_len,
    output logic [CAPS-1:0]    mask,
    output logic               leg_done
);
    localparam int PW = (CAPS > 1) ? $clog2(CAPS) : 1;

    logic [PW-1:0] ptr;
    logic [QW-1:0] cnt;
    logic [VW-1:0] v_sel;
    logic [VW-1:0] t_sel;
    logic [QW:0]   cnt_inc;
    logic [QW:0]   q_eff;
    logic          hit;
    logic          step;

    always_comb begin
        v_sel = '0;
        t_sel = '0;
        for (int k = 0; k < CAPS; k++) begin
            if (ptr == PW'(k)) begin
                v_sel = v_leg[k*VW +: VW];
                t_sel = thr[k*VW +: VW];
            end
        end
        hit     = (v_sel >= t_sel);
        cnt_inc = {1'b0, cnt} + (QW+1)'(1);
        q_eff   = (qual_len == '0) ? (QW+1)'(1) : {1'b0, qual_len};
        step    = run && !leg_done && v_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask     <= '1;
            ptr      <= PW'(CAPS - 1);
            cnt      <= '0;
            leg_done <= 1'b0;
        end else if (arm) begin
            mask     <= '1;
            ptr      <= PW'(CAPS - 1);
            cnt      <= '0;
            leg_done <= 1'b0;
        end else if (step) begin
            if (hit) begin
                if (cnt_inc >= q_eff) begin
                    mask <= mask & ~(CAPS'(1) << ptr);
                    cnt  <= '0;
                    if (ptr == '0) leg_done <= 1'b1;
                    else           ptr      <= ptr - 1'b1;
                end else begin
                    cnt <= cnt_inc[QW-1:0];
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    // R5: outside arming, switch bits only ever clear
    mask_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> ((mask & ~$past(mask)) == '0));

    // R4
    release_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> ($countones($past(mask) & ~mask) <= 1));

    // R7
    leg_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        leg_done |-> (mask == '0));
endmodule

// File: rtl/fcpc_seq.sv
// Sequencing state machine with charge-window counter.
module fcpc_seq #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          all_done,
    input  logic [TW-1:0] timeout_lim,
    output logic          arm,
    output logic          run,
    output logic          sw_gate,
    output logic          done,
    output logic          fault
);
    import fcpc_pkg::*;

    pc_state_e     state;
    pc_state_e     state_nx;
    logic [TW-1:0] tmo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   tmo_cnt <= '0;
        else if (state != ST_CHARGE)  tmo_cnt <= '0;
        else if (tmo_cnt != '1)       tmo_cnt <= tmo_cnt + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    state_nx = en ? ST_CONNECT : ST_IDLE;
            ST_CONNECT: state_nx = en ? ST_CHARGE  : ST_IDLE;
            ST_CHARGE: begin
                if (!en)                          state_nx = ST_IDLE;
                else if (all_done)                state_nx = ST_DONE;
                else if (tmo_cnt == timeout_lim)  state_nx = ST_FAULT;
                else                              state_nx = ST_CHARGE;
            end
            ST_DONE:    state_nx = en ? ST_DONE  : ST_IDLE;
            ST_FAULT:   state_nx = en ? ST_FAULT : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        arm     = 1'b0;
        run     = 1'b0;
        sw_gate = 1'b0;
        done    = 1'b0;
        fault   = 1'b0;
        unique case (state)
            ST_IDLE:    arm = 1'b1;
            ST_CONNECT: sw_gate = 1'b1;
            ST_CHARGE: begin
                sw_gate = 1'b1;
                run     = 1'b1;
            end
            ST_DONE:    done  = 1'b1;
            ST_FAULT:   fault = 1'b1;
            default:    arm = 1'b1;
        endcase
    end

    // R10
    enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE));

    // R9
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_DONE) |-> $past(all_done));

    // R8
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_FAULT) |-> ($past(tmo_cnt) == $past(timeout_lim)) && !$past(all_done));

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT) && en |=> (state == ST_FAULT));
endmodule

// File: rtl/fcpc_precharge.sv
module fcpc_precharge #(
    parameter int PHASES = 3,
    parameter int LEVELS = 5,
    parameter int VW     = 12,
    parameter int QW     = 4,
    parameter int TW     = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            en,
    input  logic                            v_valid,
    input  logic [PHASES*(LEVELS-2)*VW-1:0] v_cap,
    input  logic [VW-1:0]                   vdc_target,
    input  logic [VW-1:0]                   margin,
    input  logic [QW-1:0]                   qual_len,
    input  logic [TW-1:0]                   timeout_lim,
    output logic [PHASES*(LEVELS-2)-1:0]    sw_cmd,
    output logic                            done,
    output logic                            fault
);
    localparam int CAPS = LEVELS - 2;
    localparam int NSW  = PHASES * CAPS;

    logic [CAPS*VW-1:0] thr;
    logic [NSW-1:0]     mask_all;
    logic [PHASES-1:0]  leg_done_v;
    logic               all_done;
    logic               arm;
    logic               run;
    logic               sw_gate;

    fcpc_thresh #(.LEVELS(LEVELS), .VW(VW)) u_thresh (
        .vdc_target (vdc_target),
        .margin     (margin),
        .thr        (thr)
    );

    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_phase
            fcpc_leg #(.CAPS(CAPS), .VW(VW), .QW(QW)) u_leg (
                .clk      (clk),
                .rst_n    (rst_n),
                .arm      (arm),
                .run      (run),
                .v_valid  (v_valid),
                .v_leg    (v_cap[p*CAPS*VW +: CAPS*VW]),
                .thr      (thr),
                .qual_len (qual_len),
                .mask     (mask_all[p*CAPS +: CAPS]),
                .leg_done (leg_done_v[p])
            );
        end
    endgenerate

    assign all_done = &leg_done_v;

    fcpc_seq #(.TW(TW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .all_done    (all_done),
        .timeout_lim (timeout_lim),
        .arm         (arm),
        .run         (run),
        .sw_gate     (sw_gate),
        .done        (done),
        .fault       (fault)
    );

    assign sw_cmd = sw_gate ? mask_all : '0;

    // R2
    connect_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_gate && !run) |-> (sw_cmd == {NSW{1'b1}}));

    // R1
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> (sw_cmd == '0) && !done && !fault);
endmodule

// File: tb/fcpc_precharge_tb.sv
module fcpc_precharge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PHASES = 3;
    localparam int LEVELS = 5;
    localparam int VW = 12;
    localparam int QW = 4;
    localparam int TW = 16;
    localparam int CAPS = LEVELS - 2;
    localparam int NSW = PHASES * CAPS;
    localparam int ALL_ON = 9'h1FF;
    localparam int K2_OFF = 9'h0DB;
    localparam int K1_OFF = 9'h049;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic                     en;
    logic                     v_valid;
    logic [NSW*VW-1:0]        v_cap;
    logic [VW-1:0]            vdc_target;
    logic [VW-1:0]            margin;
    logic [QW-1:0]            qual_len;
    logic [TW-1:0]            timeout_lim;
    logic [NSW-1:0]           sw_cmd;
    logic                     done;
    logic                     fault;
    logic [VW-1:0]            vb [PHASES][CAPS];

    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    bit sb_on = 1'b0;
    logic [NSW-1:0] prev_sw = '0;
    int mon_e;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int p = 0; p < PHASES; p++)
            for (int k = 0; k < CAPS; k++)
                v_cap[(p*CAPS+k)*VW +: VW] = vb[p][k];
    end

    fcpc_precharge #(.PHASES(PHASES), .LEVELS(LEVELS), .VW(VW), .QW(QW), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .v_valid(v_valid), .v_cap(v_cap),
        .vdc_target(vdc_target), .margin(margin), .qual_len(qual_len),
        .timeout_lim(timeout_lim), .sw_cmd(sw_cmd), .done(done), .fault(fault)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_caps(input int v0, input int v1, input int v2);
        for (int p = 0; p < PHASES; p++) begin
            vb[p][0] = VW'(v0);
            vb[p][1] = VW'(v1);
            vb[p][2] = VW'(v2);
        end
    endtask

    task automatic sample();
        v_valid = 1'b1;
        @(negedge clk);
        v_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic start();
        en = 1'b1;
        tick(1);
        chk(sw_cmd == NSW'(ALL_ON), "R2 connect all on", int'(sw_cmd), ALL_ON);
        tick(1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // scoreboard monitor: pops expected releases as switch bits fall
    always @(negedge clk) begin
        if (sb_on) begin
            for (int k = CAPS-1; k >= 0; k--) begin
                for (int p = 0; p < PHASES; p++) begin
                    if (prev_sw[p*CAPS+k] && !sw_cmd[p*CAPS+k]) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R4 unexpected release", p*16+k, -1);
                        end else begin
                            mon_e = exp_q.pop_front();
                            chk(mon_e == p*16+k, "R4 release order", p*16+k, mon_e);
                        end
                    end
                end
            end
        end
        prev_sw = sw_cmd;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; v_valid = 1'b0;
        vdc_target = VW'(1200); margin = VW'(10); qual_len = QW'(3);
        timeout_lim = TW'(5000);
        set_caps(0, 0, 0);
        tick(3);
        chk(sw_cmd == '0 && !done && !fault, "R1 in reset", int'(sw_cmd), 0);
        rst_n = 1'b1;
        tick(3);
        chk(sw_cmd == '0 && !done && !fault, "R1 idle after reset", int'(sw_cmd), 0);

        // main sequence
        start();
        chk(sw_cmd == NSW'(ALL_ON), "R2 charge all on", int'(sw_cmd), ALL_ON);
        set_caps(0, 0, 290); sample(); sample();
        set_caps(0, 0, 289); sample();
        set_caps(0, 0, 290); sample(); sample();
        chk(sw_cmd == NSW'(ALL_ON), "R5 count restarted by low sample", int'(sw_cmd), ALL_ON);
        sample();
        chk(sw_cmd == NSW'(K2_OFF), "R3 R5 release at threshold", int'(sw_cmd), K2_OFF);

        set_caps(1000, 0, 0); sample(); sample(); sample();
        chk(sw_cmd == NSW'(K2_OFF), "R4 non-pending capacitor ignored", int'(sw_cmd), K2_OFF);

        set_caps(1000, 600, 0);
        tick(8);
        chk(sw_cmd == NSW'(K2_OFF), "R6 no strobe no release", int'(sw_cmd), K2_OFF);

        for (int p = 0; p < PHASES; p++) exp_q.push_back(p*16+1);
        for (int p = 0; p < PHASES; p++) exp_q.push_back(p*16+0);
        sb_on = 1'b1;
        sample(); sample(); sample();
        chk(sw_cmd == NSW'(K1_OFF), "R4 second release", int'(sw_cmd), K1_OFF);
        set_caps(700, 600, 0); sample();
        set_caps(800, 600, 0); sample();
        set_caps(900, 600, 0); sample(); sample();
        chk(!done, "R7 not done early", int'(done), 0);
        sample();
        chk(done && !fault, "R7 done raised", int'(done), 1);
        chk(sw_cmd == '0, "R7 switches open", int'(sw_cmd), 0);
        sb_on = 1'b0;
        chk(exp_q.size() == 0, "R4 all releases seen", exp_q.size(), 0);

        en = 1'b0; tick(1);
        chk(!done && sw_cmd == '0, "R10 drop from done", int'(done), 0);

        // drop during charge
        set_caps(0, 0, 0);
        start();
        en = 1'b0; tick(1);
        chk(sw_cmd == '0 && !fault && !done, "R10 drop mid charge", int'(sw_cmd), 0);

        // charge window expiry
        timeout_lim = TW'(20);
        en = 1'b1;
        tick(22);
        chk(!fault && sw_cmd == NSW'(ALL_ON), "R8 no fault before limit", int'(fault), 0);
        tick(1);
        chk(fault && !done, "R8 fault raised", int'(fault), 1);
        chk(sw_cmd == '0, "R8 switches open on fault", int'(sw_cmd), 0);
        tick(5);
        chk(fault, "R8 fault held", int'(fault), 1);
        en = 1'b0; tick(1);
        chk(!fault, "R10 fault cleared", int'(fault), 0);

        // completion and expiry in the same cycle
        qual_len = QW'(0);
        timeout_lim = TW'(3);
        set_caps(1000, 1000, 1000);
        v_valid = 1'b1;
        en = 1'b1;
        tick(6);
        chk(done && !fault, "R9 completion wins tie", int'(fault), 0);
        en = 1'b0; tick(1);

        timeout_lim = TW'(2);
        en = 1'b1;
        tick(5);
        chk(fault && !done, "R8 R9 expiry one cycle earlier", int'(fault), 1);
        en = 1'b0; v_valid = 1'b0; tick(1);
        chk(sw_cmd == '0 && !fault && !done, "R1 back in idle", int'(sw_cmd), 0);

        finish_run();
    end
endmodule